// File: doc/BRIEF.md
# Three-Stage Shared Memory Bank Arbiter

This block decides, once per cycle, which bus master gets the single access slot of one bank of a banked shared memory. Every bank has its own copy of the block, and each master has a private request line into every copy. Twelve masters compete: eight processor pairs, each contributing four cache ports (instruction and data for each of two cores), plus a network transmit engine, a debug unit, a manager core and a network receive engine.

The decision is made in three stages. Inside each processor pair the four cache ports are merged round-robin. The eight pair winners then compete round-robin with transmit, debug and the manager core. Finally network receive meets the stage-two winner under fixed priority and always wins. The outcome is registered: one cycle after a request is presented, exactly one grant bit pulses for one cycle, together with an index of the winning master and, for a processor pair, the port inside the pair.

Top module: `bank_arbiter`

## Requirements
- R1: While reset is high and in the first cycle after it, every grant output, `gnt_valid`, `gnt_master` and `gnt_port` are zero, and every round-robin pointer starts at position 0.
- R2: Requests sampled at a clock edge produce the grant after that edge and hold it for one cycle; at most one grant bit is set, a grant is only given to a source that was requesting, and whenever any source requests some source is granted.
- R3: When network receive requests, it is granted in the next cycle regardless of any other request.
- R4: Inside a pair the four ports are ranked from the pointer upwards with wrap, using port order 0 = core A instruction, 1 = core A data, 2 = core B instruction, 3 = core B data; after a used grant the pointer moves to the port just after the winner.
- R5: Stage two ranks its eleven sources from its pointer upwards with wrap in the order pairs 0..7, then transmit (8), debug (9), manager (10); after a used grant the pointer moves just past the winner. When only pairs request, service rotates among pairs in this order.
- R6: A round-robin pointer advances only when its candidate actually wins the final stage; a cycle taken by network receive leaves every pointer unchanged.
- R7: With no requests, nothing is granted and all pointers keep their values.
- R8: With sources requesting continuously at stage two, a requesting source sees at most ten grants to other stage-two sources before its own grant.
- R9: `gnt_master` encodes the winner as pair number 0..7, 8 transmit, 9 debug, 10 manager, 11 receive; `gnt_port` gives the port inside a granted pair and is 0 otherwise; `gnt_valid` is high exactly when a grant bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pe_req | input | 32 | Cache port requests, bit pair*4+port |
| tx_req | input | 1 | Network transmit request |
| dbg_req | input | 1 | Debug unit request |
| mgr_req | input | 1 | Manager core request |
| rx_req | input | 1 | Network receive request |
| pe_gnt | output | 32 | Cache port grants, same bit layout as pe_req |
| tx_gnt | output | 1 | Network transmit grant |
| dbg_gnt | output | 1 | Debug unit grant |
| mgr_gnt | output | 1 | Manager core grant |
| rx_gnt | output | 1 | Network receive grant |
| gnt_valid | output | 1 | A grant is present this cycle |
| gnt_master | output | 4 | Index of the granted master |
| gnt_port | output | 2 | Port inside the granted pair |

## Verification
The bench aims at the interplay of the stages: a receive burst in the middle of a rotation, where a design that advanced its pointers on lost grants would skip a port or a pair once receive goes quiet. It holds all four ports of a pair and all eleven stage-two sources high so that a pointer that returned to zero instead of moving past the winner would starve the upper positions, and it inserts idle cycles where a design that drifted its pointers or raised a spurious grant would break the expected order. Random mixes with sparse receive traffic compare every grant, master index and port against an independent model.

// File: rtl/bank_arb_pkg.sv
package bank_arb_pkg;

    localparam int DEF_PAIRS  = 8;
    localparam int DEF_PORTS  = 4;
    localparam int EXTRA_S2   = 3;   // transmit, debug, manager

    // Outcome of the final fixed-priority stage
    typedef enum logic [1:0] {
        WIN_NONE = 2'd0,
        WIN_S2   = 2'd1,
        WIN_RX   = 2'd2
    } win_e;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/rr_arb.sv
module rr_arb #(
    parameter int N = 4,
    localparam int IW = bank_arb_pkg::idx_width(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req,
    input  logic          adv,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] idx,
    output logic          any
);

    logic [IW-1:0] ptr;

    // Search upward from the pointer with wrap-around
    always_comb begin
        gnt = '0;
        idx = '0;
        any = 1'b0;
        for (int k = 0; k < N; k++) begin
            int j;
            j = int'(ptr) + k;
            if (j >= N) j = j - N;
            if (!any && req[j]) begin
                any    = 1'b1;
                idx    = IW'(j);
                gnt[j] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (adv && any) begin
            ptr <= (int'(idx) == N - 1) ? '0 : idx + 1'b1;
        end
    end

endmodule

// File: rtl/prio_stage.sv
module prio_stage
    import bank_arb_pkg::*;
(
    input  logic rx_req,
    input  logic cand,
    output win_e win
);

    always_comb begin
        if (rx_req)    win = WIN_RX;
        else if (cand) win = WIN_S2;
        else           win = WIN_NONE;
    end

endmodule

// File: rtl/bank_arbiter.sv
module bank_arbiter
    import bank_arb_pkg::*;
#(
    parameter int NPAIR = DEF_PAIRS,
    parameter int PORTS = DEF_PORTS,
    localparam int NPE  = NPAIR * PORTS,
    localparam int NS2  = NPAIR + EXTRA_S2,
    localparam int S2W  = idx_width(NS2),
    localparam int MW   = idx_width(NS2 + 1),
    localparam int PW   = idx_width(PORTS)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NPE-1:0] pe_req,
    input  logic           tx_req,
    input  logic           dbg_req,
    input  logic           mgr_req,
    input  logic           rx_req,
    output logic [NPE-1:0] pe_gnt,
    output logic           tx_gnt,
    output logic           dbg_gnt,
    output logic           mgr_gnt,
    output logic           rx_gnt,
    output logic           gnt_valid,
    output logic [MW-1:0]  gnt_master,
    output logic [PW-1:0]  gnt_port
);

    logic [NPAIR-1:0] pair_any;
    logic [NPAIR-1:0] s1_adv;
    logic [NPE-1:0]   s1_gnt;
    logic [PW-1:0]    s1_idx [NPAIR];

    logic [NS2-1:0]   s2_req;
    logic [NS2-1:0]   s2_gnt;
    logic [S2W-1:0]   s2_idx;
    logic             s2_any;
    win_e             win;

    // Stage one: one round-robin per processor pair
    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        rr_arb #(.N(PORTS)) u_s1 (
            .clk (clk),
            .rst (rst),
            .req (pe_req[p*PORTS +: PORTS]),
            .adv (s1_adv[p]),
            .gnt (s1_gnt[p*PORTS +: PORTS]),
            .idx (s1_idx[p]),
            .any (pair_any[p])
        );
        assign s1_adv[p] = s2_gnt[p] && (win == WIN_S2);
    end

    // Stage two: pair winners plus transmit, debug, manager
    assign s2_req = {mgr_req, dbg_req, tx_req, pair_any};

    rr_arb #(.N(NS2)) u_s2 (
        .clk (clk),
        .rst (rst),
        .req (s2_req),
        .adv (win == WIN_S2),
        .gnt (s2_gnt),
        .idx (s2_idx),
        .any (s2_any)
    );

    // Stage three: receive over everything else
    prio_stage u_s3 (
        .rx_req (rx_req),
        .cand   (s2_any),
        .win    (win)
    );

    logic [NPE-1:0] pe_gnt_d;
    logic           tx_d, dbg_d, mgr_d, rx_d, valid_d;
    logic [MW-1:0]  master_d;
    logic [PW-1:0]  port_d;

    always_comb begin
        pe_gnt_d = '0;
        tx_d     = 1'b0;
        dbg_d    = 1'b0;
        mgr_d    = 1'b0;
        rx_d     = 1'b0;
        valid_d  = 1'b0;
        master_d = '0;
        port_d   = '0;
        case (win)
            WIN_RX: begin
                rx_d     = 1'b1;
                valid_d  = 1'b1;
                master_d = MW'(NS2);
            end
            WIN_S2: begin
                valid_d  = 1'b1;
                master_d = MW'(s2_idx);
                tx_d     = s2_gnt[NPAIR];
                dbg_d    = s2_gnt[NPAIR+1];
                mgr_d    = s2_gnt[NPAIR+2];
                for (int p = 0; p < NPAIR; p++) begin
                    if (s2_gnt[p]) begin
                        pe_gnt_d[p*PORTS +: PORTS] = s1_gnt[p*PORTS +: PORTS];
                        port_d = s1_idx[p];
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pe_gnt     <= '0;
            tx_gnt     <= 1'b0;
            dbg_gnt    <= 1'b0;
            mgr_gnt    <= 1'b0;
            rx_gnt     <= 1'b0;
            gnt_valid  <= 1'b0;
            gnt_master <= '0;
            gnt_port   <= '0;
        end else begin
            pe_gnt     <= pe_gnt_d;
            tx_gnt     <= tx_d;
            dbg_gnt    <= dbg_d;
            mgr_gnt    <= mgr_d;
            rx_gnt     <= rx_d;
            gnt_valid  <= valid_d;
            gnt_master <= master_d;
            gnt_port   <= port_d;
        end
    end

endmodule

// File: rtl/bank_arbiter_chk.sv
module bank_arbiter_chk #(
    parameter int NPAIR = 8,
    parameter int PORTS = 4,
    localparam int NPE  = NPAIR * PORTS,
    localparam int NS2  = NPAIR + 3,
    localparam int MW   = bank_arb_pkg::idx_width(NS2 + 1),
    localparam int PW   = bank_arb_pkg::idx_width(PORTS),
    localparam int CW   = $clog2(NS2) + 2
) (
    input logic           clk,
    input logic           rst,
    input logic [NPE-1:0] pe_req,
    input logic           tx_req,
    input logic           dbg_req,
    input logic           mgr_req,
    input logic           rx_req,
    input logic [NPE-1:0] pe_gnt,
    input logic           tx_gnt,
    input logic           dbg_gnt,
    input logic           mgr_gnt,
    input logic           rx_gnt,
    input logic           gnt_valid,
    input logic [MW-1:0]  gnt_master,
    input logic [PW-1:0]  gnt_port
);

    logic [NPE+3:0] all_gnt;
    logic           any_req;
    logic [NS2-1:0] s2_req_now;

    assign all_gnt = {rx_gnt, mgr_gnt, dbg_gnt, tx_gnt, pe_gnt};
    assign any_req = (|pe_req) | tx_req | dbg_req | mgr_req | rx_req;

    for (genvar p = 0; p < NPAIR; p++) begin : g_or
        assign s2_req_now[p] = |pe_req[p*PORTS +: PORTS];
    end
    assign s2_req_now[NS2-1:NPAIR] = {mgr_req, dbg_req, tx_req};

    // R2: never more than one grant
    p_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(all_gnt));

    // R2: some request leads to a grant in the next cycle
    p_work_r2: assert property (@(posedge clk) disable iff (rst)
        any_req |=> gnt_valid);

    // R3: receive always wins
    p_rx_wins_r3: assert property (@(posedge clk) disable iff (rst)
        rx_req |=> rx_gnt);

    // R7: idle means no grant
    p_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !any_req |=> !gnt_valid);

    // R9: valid flag tracks the grant bits
    p_valid_r9: assert property (@(posedge clk) disable iff (rst)
        gnt_valid == (|all_gnt));

    // R2: a port grant was requested in the cycle before
    for (genvar i = 0; i < NPE; i++) begin : g_pe
        p_had_req_r2: assert property (@(posedge clk) disable iff (rst)
            pe_gnt[i] |-> $past(pe_req[i]));
    end

    // R8: wait counters per stage-two source
    logic [NS2-1:0] pend_q;
    for (genvar m = 0; m < NS2; m++) begin : g_fair
        logic [CW-1:0] wait_cnt;
        always_ff @(posedge clk) begin
            if (rst) begin
                wait_cnt <= '0;
            end else if (!pend_q[m] || (gnt_valid && int'(gnt_master) == m)) begin
                wait_cnt <= '0;
            end else if (gnt_valid && int'(gnt_master) < NS2) begin
                wait_cnt <= wait_cnt + 1'b1;
            end
        end
        p_fair_r8: assert property (@(posedge clk) disable iff (rst)
            int'(wait_cnt) <= NS2 - 1);
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= s2_req_now;
    end

endmodule

bind bank_arbiter bank_arbiter_chk #(.NPAIR(NPAIR), .PORTS(PORTS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pe_req     (pe_req),
    .tx_req     (tx_req),
    .dbg_req    (dbg_req),
    .mgr_req    (mgr_req),
    .rx_req     (rx_req),
    .pe_gnt     (pe_gnt),
    .tx_gnt     (tx_gnt),
    .dbg_gnt    (dbg_gnt),
    .mgr_gnt    (mgr_gnt),
    .rx_gnt     (rx_gnt),
    .gnt_valid  (gnt_valid),
    .gnt_master (gnt_master),
    .gnt_port   (gnt_port)
);

// File: tb/tb_bank_arbiter.sv
module tb_bank_arbiter;

    localparam int NP  = 8;
    localparam int NPO = 4;
    localparam int NS  = NP + 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pe_req = '0;
    logic        tx_req = 1'b0, dbg_req = 1'b0, mgr_req = 1'b0, rx_req = 1'b0;
    logic [31:0] pe_gnt;
    logic        tx_gnt, dbg_gnt, mgr_gnt, rx_gnt, gnt_valid;
    logic [3:0]  gnt_master;
    logic [1:0]  gnt_port;

    always #5 clk = ~clk;

    bank_arbiter dut (
        .clk(clk), .rst(rst), .pe_req(pe_req),
        .tx_req(tx_req), .dbg_req(dbg_req), .mgr_req(mgr_req), .rx_req(rx_req),
        .pe_gnt(pe_gnt), .tx_gnt(tx_gnt), .dbg_gnt(dbg_gnt), .mgr_gnt(mgr_gnt),
        .rx_gnt(rx_gnt), .gnt_valid(gnt_valid), .gnt_master(gnt_master),
        .gnt_port(gnt_port)
    );

    typedef struct {
        logic [35:0] vec;
        logic        valid;
        logic [3:0]  master;
        logic [1:0]  port;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_vec  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    // Reference pointers
    int p1 [NP];
    int p2;

    function automatic int pick(input logic [15:0] req, input int n, input int ptr);
        for (int k = 0; k < n; k++) begin
            int j = (ptr + k) % n;
            if (req[j]) return j;
        end
        return -1;
    endfunction

    task automatic apply(input logic [31:0] pe, input logic tx, input logic dbg,
                         input logic mgr, input logic rx, input string tag);
        exp_t e;
        logic [15:0] s2r;
        int w1 [NP];
        int w2;
        s2r = '0;
        for (int p = 0; p < NP; p++) begin
            w1[p] = pick(16'(pe[p*4 +: 4]), NPO, p1[p]);
            s2r[p] = (w1[p] >= 0);
        end
        s2r[8] = tx; s2r[9] = dbg; s2r[10] = mgr;
        w2 = pick(s2r, NS, p2);
        e.vec = '0; e.valid = 1'b0; e.master = '0; e.port = '0; e.tag = tag;
        if (rx) begin
            e.vec[35] = 1'b1; e.valid = 1'b1; e.master = 4'd11;
        end else if (w2 >= 0) begin
            e.valid = 1'b1;
            e.master = 4'(w2);
            if (w2 < NP) begin
                e.vec[w2*4 + w1[w2]] = 1'b1;
                e.port = 2'(w1[w2]);
                p1[w2] = (w1[w2] + 1) % NPO;
            end else begin
                e.vec[32 + w2 - NP] = 1'b1;
            end
            p2 = (w2 + 1) % NS;
        end
        @(negedge clk);
        pe_req = pe; tx_req = tx; dbg_req = dbg; mgr_req = mgr; rx_req = rx;
        exp_q.push_back(e);
    endtask

    // Monitor: compares each cycle's grant against the oldest expectation
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                logic [35:0] got;
                e = exp_q.pop_front();
                got = {rx_gnt, mgr_gnt, dbg_gnt, tx_gnt, pe_gnt};
                n_vec++;
                if (got !== e.vec || gnt_valid !== e.valid ||
                    gnt_master !== e.master || gnt_port !== e.port) begin
                    n_fail++;
                    $display("FAIL %s: grants %h valid %b master %0d port %0d, expected %h valid %b master %0d port %0d",
                             e.tag, got, gnt_valid, gnt_master, gnt_port,
                             e.vec, e.valid, e.master, e.port);
                end
            end
        end
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not end, expected completion");
            finish_run();
        end
    end

    initial begin
        for (int p = 0; p < NP; p++) p1[p] = 0;
        p2 = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: outputs clear out of reset
        n_vec++;
        if ({rx_gnt, mgr_gnt, dbg_gnt, tx_gnt, pe_gnt} !== '0 || gnt_valid !== 1'b0 ||
            gnt_master !== '0 || gnt_port !== '0) begin
            n_fail++;
            $display("FAIL R1: grants %h valid %b, expected 0 0",
                     {rx_gnt, mgr_gnt, dbg_gnt, tx_gnt, pe_gnt}, gnt_valid);
        end

        // R7: idle cycles
        repeat (3) apply('0, 0, 0, 0, 0, "R7 idle");

        // R4: pair 2 all ports steady, rotation 0,1,2,3,0
        repeat (6) apply(32'h0000_0F00, 0, 0, 0, 0, "R4 pair rotation");

        // R4: sparse ports inside pair 5 (ports 1 and 3)
        repeat (4) apply(32'h00A0_0000, 0, 0, 0, 0, "R4 sparse ports");

        // R7: pointers hold across idle
        repeat (2) apply('0, 0, 0, 0, 0, "R7 hold");
        repeat (2) apply(32'h0000_0F00, 0, 0, 0, 0, "R7 resume");

        // R5: only pairs requesting, one port each
        repeat (10) apply(32'h1111_1111, 0, 0, 0, 0, "R5 pair rotation");

        // R8: all stage-two sources steady, every one served within a round
        repeat (24) apply(32'hFFFF_FFFF, 1, 1, 1, 0, "R8 full load");

        // R3 / R6: receive burst in mid-rotation, then order resumes
        repeat (2) apply(32'h0000_000F, 1, 0, 0, 0, "R6 before burst");
        repeat (3) apply(32'h0000_000F, 1, 0, 0, 1, "R3 receive wins");
        repeat (4) apply(32'h0000_000F, 1, 0, 0, 0, "R6 after burst");

        // R3: receive alone
        apply('0, 0, 0, 0, 1, "R3 receive alone");

        // R9: individual masters for index encoding
        apply('0, 1, 0, 0, 0, "R9 transmit index");
        apply('0, 0, 1, 0, 0, "R9 debug index");
        apply('0, 0, 0, 1, 0, "R9 manager index");
        apply(32'h8000_0000, 0, 0, 0, 0, "R9 last port index");

        // R2: random mixes with sparse receive traffic
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            r = $urandom() & $urandom();
            apply(r, 1'($urandom()), 1'($urandom()), 1'($urandom()),
                  ($urandom() % 8) == 0, "R2 random");
        end

        apply('0, 0, 0, 0, 0, "R7 final idle");
        while (exp_q.size() > 0) @(posedge clk);
        @(negedge clk);
        done = 1;
        finish_run();
    end

endmodule